// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming front end of an eight-line interrupt controller. A host reaches it through a two-address byte bus. Writes to the even address are sorted by their data bits into a start-of-initialization word or one of two operation commands. Writes to the odd address feed the later initialization steps, or load the line mask once initialization is over. The block holds the mode flags, the vector base, the mask, the rotating priority offset and the read-select and poll state. It turns end-of-interrupt commands into single-cycle clear pulses for the in-service register that lives outside it.

The priority resolver is also outside the block. Two resolver results come in as ports: the highest-priority line that is in service, and the highest-priority line that is pending. The first serves non-specific end-of-interrupt commands. The second serves poll reads. A separate write port loads an edge/level trigger register. Only the bits allowed by a per-instance parameter can be set in it. Selecting level-triggered mode through the initialization word is not supported: that bit is ignored.

Top module: `icu_cmd_seq`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialization. During that cycle `init_clear` pulses. From the next cycle `init_active` is 1. The need-mode-word flag is taken from bit 0 and `single_mode` from bit 1. The mask, priority offset, rotate flag, special mask, poll, read select (back to request register), `nested_mode` and `auto_eoi` are all cleared.
- R2: The first address-1 write after the start word loads `vec_base` with data AND 0xF8. The next step is the mode word if single mode and the mode word are both flagged. It is idle if single mode is set without the mode word. In every other case the next step is the cascade word.
- R3: A cascade-step write has no effect on the mask. It moves to the mode-word step if the mode word was flagged, and to idle if not. A mode-word write loads `nested_mode` from bit 4 and `auto_eoi` from bit 1, then returns to idle (`init_active` 0).
- R4: An address-1 write while idle loads the line mask. During the initialization steps the mask is left unchanged.
- R5: An address-0 write with bit 4 clear and bit 3 set is the read/mode command. Bit 2 sets poll mode. Bit 0 chooses the in-service (1) or request (0) register, but only when bit 1 is set. Bit 5 loads the special mask, but only when bit 6 is set.
- R6: An address-0 write with bits 4 and 3 clear is the priority command, and its code is bits 7:5. Codes 0 and 4 load the rotate-on-auto-EOI flag from bit 2 of the code.
- R7: Code 1 is a non-specific EOI. If the resolver reports an in-service line, `eoi_valid` pulses in the write cycle with `eoi_idx` equal to that line. Code 5 does the same, and in that case also sets the offset to (line+1) mod 8. If no line is in service, neither code has any effect.
- R8: Code 3 pulses `eoi_valid` for line data[2:0]. Code 7 does the same and also sets the offset to (data[2:0]+1) mod 8. Code 6 only sets the offset to (data[2:0]+1) mod 8, with no EOI pulse. Code 2 does nothing.
- R9: `host_rdata` shows the mask when `host_addr` is 1. When `host_addr` is 0 and poll mode is off, it shows `isr_in` or `irr_in` according to the read select.
- R10: In poll mode, an address-0 read returns 0x80 OR the pending line and pulses `poll_ack_valid` with that line. If nothing is pending, the read returns 0x00 with no pulse. Either way, poll mode is cleared after the read.
- R11: A `trig_wr` write loads `trig_level` with the data AND the `TRIG_ALLOW` parameter (0xDE by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| trig_wr | input | 1 | Trigger register write strobe |
| trig_wdata | input | 8 | Trigger register write data |
| trig_level | output | 8 | Edge (0) / level (1) selection per line |
| isr_in | input | 8 | In-service register contents |
| irr_in | input | 8 | Request register contents |
| top_isr_valid | input | 1 | Resolver: some line is in service |
| top_isr_idx | input | 3 | Resolver: highest-priority in-service line |
| top_req_valid | input | 1 | Resolver: some line is pending |
| top_req_idx | input | 3 | Resolver: highest-priority pending line |
| vec_base | output | 8 | Vector base (low three bits zero) |
| line_mask | output | 8 | Line mask register |
| prio_offset | output | 3 | Rotating priority offset |
| eoi_valid | output | 1 | Clear-in-service pulse |
| eoi_idx | output | 3 | Line to clear |
| poll_ack_valid | output | 1 | Poll-read acknowledge pulse |
| poll_ack_idx | output | 3 | Line acknowledged by the poll read |
| init_clear | output | 1 | Pulse: clear external controller state |
| init_active | output | 1 | Initialization sequence in progress |
| single_mode | output | 1 | Single (non-cascaded) mode |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic EOI mode |
| rotate_aeoi | output | 1 | Rotate on automatic EOI |
| spec_mask | output | 1 | Special mask mode |
| poll_mode | output | 1 | Poll mode armed |

## Verification
The hardest cases to reach are the ones where the resolver result decides the outcome. These are a non-specific EOI with no line in service, and a poll read with nothing pending. Both must leave the offset and the acknowledge path untouched. The bench drives the resolver ports directly and switches their valid flags off between otherwise identical commands. It also starts from a nonzero offset, so that a change that should not happen would be seen. The four initialization paths are each entered with a fresh start word, and their exit is judged by whether a later address-1 write reaches the mask.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int unsigned LINES    = 8;
    localparam int unsigned IDX_W    = $clog2(LINES);
    localparam int unsigned DW       = 8;
    localparam int unsigned BASE_LSB = IDX_W;
    localparam logic [DW-1:0] BASE_MASK = {DW{1'b1}} << BASE_LSB;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        WK_ICW1 = 2'd0,
        WK_OCW2 = 2'd1,
        WK_OCW3 = 2'd2
    } wkind_e;

    typedef struct packed {
        logic rot_ld;
        logic rot_val;
        logic eoi_ns;
        logic eoi_sp;
        logic set_off;
    } ocw2_act_t;

    function automatic wkind_e classify(input logic [DW-1:0] d);
        if (d[4])      return WK_ICW1;
        else if (d[3]) return WK_OCW3;
        else           return WK_OCW2;
    endfunction

    function automatic ocw2_act_t decode_ocw2(input logic [2:0] cmd);
        ocw2_act_t a;
        a = '0;
        case (cmd)
            3'd0, 3'd4: begin
                a.rot_ld  = 1'b1;
                a.rot_val = cmd[2];
            end
            3'd1: a.eoi_ns = 1'b1;
            3'd5: begin
                a.eoi_ns  = 1'b1;
                a.set_off = 1'b1;
            end
            3'd3: a.eoi_sp = 1'b1;
            3'd7: begin
                a.eoi_sp  = 1'b1;
                a.set_off = 1'b1;
            end
            3'd6: a.set_off = 1'b1;
            default: a = '0;
        endcase
        return a;
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return i + 1'b1;
    endfunction

    function automatic step_e step_after_base(input logic single, input logic need4);
        if (single && need4)  return STEP_MODE;
        else if (single)      return STEP_IDLE;
        else                  return STEP_CASC;
    endfunction
endpackage

// File: rtl/icu_init_seq.sv
module icu_init_seq
    import icu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          icw1_wr,
    input  logic          port1_wr,
    input  logic [DW-1:0] wdata,
    output step_e         step,
    output logic          single_mode,
    output logic [DW-1:0] vec_base,
    output logic [DW-1:0] mask,
    output logic          nested_mode,
    output logic          auto_eoi
);
    logic need_mode_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            step           <= STEP_IDLE;
            need_mode_word <= 1'b0;
            single_mode    <= 1'b0;
            vec_base       <= '0;
            mask           <= '0;
            nested_mode    <= 1'b0;
            auto_eoi       <= 1'b0;
        end else if (icw1_wr) begin
            step           <= STEP_BASE;
            need_mode_word <= wdata[0];
            single_mode    <= wdata[1];
            mask           <= '0;
            nested_mode    <= 1'b0;
            auto_eoi       <= 1'b0;
        end else if (port1_wr) begin
            case (step)
                STEP_IDLE: mask <= wdata;
                STEP_BASE: begin
                    vec_base <= wdata & BASE_MASK;
                    step     <= step_after_base(single_mode, need_mode_word);
                end
                STEP_CASC: step <= need_mode_word ? STEP_MODE : STEP_IDLE;
                STEP_MODE: begin
                    nested_mode <= wdata[4];
                    auto_eoi    <= wdata[1];
                    step        <= STEP_IDLE;
                end
                default: step <= STEP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/icu_ocw_ctl.sv
module icu_ocw_ctl
    import icu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             icw1_wr,
    input  logic             ocw2_wr,
    input  logic             ocw3_wr,
    input  logic [DW-1:0]    wdata,
    input  logic             top_isr_valid,
    input  logic [IDX_W-1:0] top_isr_idx,
    input  logic             poll_taken,
    output logic [IDX_W-1:0] prio_offset,
    output logic             rotate_aeoi,
    output logic             spec_mask,
    output logic             read_isr,
    output logic             poll_mode,
    output logic             eoi_valid,
    output logic [IDX_W-1:0] eoi_idx
);
    ocw2_act_t        act;
    logic             off_ok;
    logic             unused_wbits;

    assign unused_wbits = ^wdata[4:3];
    assign act     = ocw2_wr ? decode_ocw2(wdata[7:5]) : '0;
    assign eoi_idx = act.eoi_ns ? top_isr_idx : wdata[IDX_W-1:0];
    assign eoi_valid = (act.eoi_ns && top_isr_valid) || act.eoi_sp;
    assign off_ok  = act.set_off && (!act.eoi_ns || top_isr_valid);

    always_ff @(posedge clk) begin
        if (rst || icw1_wr) begin
            prio_offset <= '0;
            rotate_aeoi <= 1'b0;
            spec_mask   <= 1'b0;
            read_isr    <= 1'b0;
            poll_mode   <= 1'b0;
        end else begin
            if (act.rot_ld) rotate_aeoi <= act.rot_val;
            if (off_ok)     prio_offset <= next_idx(eoi_idx);
            if (ocw3_wr) begin
                if (wdata[2]) poll_mode <= 1'b1;
                if (wdata[1]) read_isr  <= wdata[0];
                if (wdata[6]) spec_mask <= wdata[5];
            end else if (poll_taken) begin
                poll_mode <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/icu_rd_path.sv
module icu_rd_path
    import icu_pkg::*;
(
    input  logic             host_rd,
    input  logic             host_addr,
    input  logic             poll_mode,
    input  logic             read_isr,
    input  logic [DW-1:0]    mask,
    input  logic [DW-1:0]    isr_in,
    input  logic [DW-1:0]    irr_in,
    input  logic             top_req_valid,
    input  logic [IDX_W-1:0] top_req_idx,
    output logic [DW-1:0]    rdata,
    output logic             poll_taken,
    output logic             ack_valid,
    output logic [IDX_W-1:0] ack_idx
);
    logic [DW-1:0] poll_word;

    always_comb begin
        poll_word = '0;
        if (top_req_valid) begin
            poll_word[DW-1]      = 1'b1;
            poll_word[IDX_W-1:0] = top_req_idx;
        end
    end

    always_comb begin
        if (host_addr)      rdata = mask;
        else if (poll_mode) rdata = poll_word;
        else if (read_isr)  rdata = isr_in;
        else                rdata = irr_in;
    end

    assign poll_taken = host_rd && !host_addr && poll_mode;
    assign ack_valid  = poll_taken && top_req_valid;
    assign ack_idx    = top_req_idx;
endmodule

// File: rtl/icu_trig_reg.sv
module icu_trig_reg
    import icu_pkg::*;
#(
    parameter logic [DW-1:0] ALLOW = 8'hDE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] level
);
    always_ff @(posedge clk) begin
        if (rst)     level <= '0;
        else if (wr) level <= wdata & ALLOW;
    end
endmodule

// File: rtl/icu_cmd_seq.sv
module icu_cmd_seq
    import icu_pkg::*;
#(
    parameter logic [7:0] TRIG_ALLOW = 8'hDE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       trig_wr,
    input  logic [7:0] trig_wdata,
    output logic [7:0] trig_level,
    input  logic [7:0] isr_in,
    input  logic [7:0] irr_in,
    input  logic       top_isr_valid,
    input  logic [2:0] top_isr_idx,
    input  logic       top_req_valid,
    input  logic [2:0] top_req_idx,
    output logic [7:0] vec_base,
    output logic [7:0] line_mask,
    output logic [2:0] prio_offset,
    output logic       eoi_valid,
    output logic [2:0] eoi_idx,
    output logic       poll_ack_valid,
    output logic [2:0] poll_ack_idx,
    output logic       init_clear,
    output logic       init_active,
    output logic       single_mode,
    output logic       nested_mode,
    output logic       auto_eoi,
    output logic       rotate_aeoi,
    output logic       spec_mask,
    output logic       poll_mode
);
    wkind_e kind;
    step_e  step;
    logic   port0_wr, port1_wr;
    logic   icw1_wr, ocw2_wr, ocw3_wr;
    logic   read_isr, poll_taken;

    assign kind     = classify(host_wdata);
    assign port0_wr = host_wr && !host_addr;
    assign port1_wr = host_wr && host_addr;
    assign icw1_wr  = port0_wr && (kind == WK_ICW1);
    assign ocw2_wr  = port0_wr && (kind == WK_OCW2);
    assign ocw3_wr  = port0_wr && (kind == WK_OCW3);

    assign init_clear  = icw1_wr;
    assign init_active = (step != STEP_IDLE);

    icu_init_seq u_init (
        .clk(clk), .rst(rst), .icw1_wr(icw1_wr), .port1_wr(port1_wr),
        .wdata(host_wdata), .step(step), .single_mode(single_mode),
        .vec_base(vec_base), .mask(line_mask), .nested_mode(nested_mode),
        .auto_eoi(auto_eoi)
    );

    icu_ocw_ctl u_ocw (
        .clk(clk), .rst(rst), .icw1_wr(icw1_wr), .ocw2_wr(ocw2_wr),
        .ocw3_wr(ocw3_wr), .wdata(host_wdata), .top_isr_valid(top_isr_valid),
        .top_isr_idx(top_isr_idx), .poll_taken(poll_taken),
        .prio_offset(prio_offset), .rotate_aeoi(rotate_aeoi),
        .spec_mask(spec_mask), .read_isr(read_isr), .poll_mode(poll_mode),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx)
    );

    icu_rd_path u_rd (
        .host_rd(host_rd), .host_addr(host_addr), .poll_mode(poll_mode),
        .read_isr(read_isr), .mask(line_mask), .isr_in(isr_in),
        .irr_in(irr_in), .top_req_valid(top_req_valid),
        .top_req_idx(top_req_idx), .rdata(host_rdata),
        .poll_taken(poll_taken), .ack_valid(poll_ack_valid),
        .ack_idx(poll_ack_idx)
    );

    icu_trig_reg #(.ALLOW(TRIG_ALLOW)) u_trig (
        .clk(clk), .rst(rst), .wr(trig_wr), .wdata(trig_wdata),
        .level(trig_level)
    );
endmodule

// File: rtl/icu_cmd_seq_chk.sv
module icu_cmd_seq_chk #(
    parameter logic [7:0] TRIG_ALLOW = 8'hDE
) (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic [7:0] trig_level,
    input logic [7:0] line_mask,
    input logic [2:0] prio_offset,
    input logic       eoi_valid,
    input logic [2:0] eoi_idx,
    input logic       poll_ack_valid,
    input logic [2:0] poll_ack_idx,
    input logic       init_active,
    input logic       poll_mode
);
    // R1: start word opens initialization and clears mask and offset
    assert_init_start_R1: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_addr && host_wdata[4]
        |=> init_active && line_mask == 8'h00 && prio_offset == 3'd0);

    // R4: idle address-1 write lands in the mask
    assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_addr && !init_active
        |=> line_mask == $past(host_wdata));

    // R7: no EOI pulse without a host write to address 0
    assert_eoi_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> host_wr && !host_addr);

    // R8: specific EOI (code 3) targets the data line
    assert_spec_eoi_R8: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_addr && host_wdata[7:3] == 5'b01100
        |-> eoi_valid && eoi_idx == host_wdata[2:0]);

    // R8: code 6 sets offset, never clears a line
    assert_set_prio_R8: assert property (@(posedge clk) disable iff (rst)
        host_wr && !host_addr && host_wdata[7:3] == 5'b11000
        |=> prio_offset == $past(host_wdata[2:0]) + 3'd1);

    // R10: poll acknowledge matches the returned word
    assert_poll_word_R10: assert property (@(posedge clk) disable iff (rst)
        poll_ack_valid |-> host_rdata[7] && host_rdata[2:0] == poll_ack_idx);

    // R10: poll mode ends after a poll read
    assert_poll_clear_R10: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_addr && poll_mode && !host_wr |=> !poll_mode);

    // R11: disallowed trigger bits stay zero
    assert_trig_allow_R11: assert property (@(posedge clk) disable iff (rst)
        (trig_level & ~TRIG_ALLOW) == 8'h00);
endmodule

bind icu_cmd_seq icu_cmd_seq_chk #(.TRIG_ALLOW(TRIG_ALLOW)) u_chk (.*);

// File: tb/tb_icu_cmd_seq.sv
`timescale 1ns/1ps
module tb_icu_cmd_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr = 0, host_rd = 0, host_addr = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       trig_wr = 0;
    logic [7:0] trig_wdata = 0, trig_level;
    logic [7:0] isr_in = 0, irr_in = 0;
    logic       top_isr_valid = 0, top_req_valid = 0;
    logic [2:0] top_isr_idx = 0, top_req_idx = 0;
    logic [7:0] vec_base, line_mask;
    logic [2:0] prio_offset, eoi_idx, poll_ack_idx;
    logic       eoi_valid, poll_ack_valid, init_clear, init_active;
    logic       single_mode, nested_mode, auto_eoi, rotate_aeoi, spec_mask, poll_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    icu_cmd_seq dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // write; returns combinational outputs seen during the write cycle
    task automatic wr(input logic a, input logic [7:0] d,
                      output logic ev, output logic [2:0] ei, output logic clr);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        #1; ev = eoi_valid; ei = eoi_idx; clr = init_clear;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic wrq(input logic a, input logic [7:0] d);
        logic ev, clr; logic [2:0] ei;
        wr(a, d, ev, ei, clr);
    endtask

    task automatic rd(input logic a, output logic [7:0] dat,
                      output logic av, output logic [2:0] ai);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        #1; dat = host_rdata; av = poll_ack_valid; ai = poll_ack_idx;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic t_reset();
        chk("R4 reset mask", line_mask, 0);
        chk("R1 reset init_active", init_active, 0);
        chk("R2 reset vec_base", vec_base, 0);
        chk("R11 reset trig", trig_level, 0);
    endtask

    task automatic t_init_cascade_mode();
        logic ev, clr; logic [2:0] ei;
        wr(0, 8'h11, ev, ei, clr);
        chk("R1 init_clear pulse", clr, 1);
        chk("R1 init_active", init_active, 1);
        chk("R1 single flag", single_mode, 0);
        wrq(1, 8'h4F);
        chk("R2 vector base", vec_base, 8'h48);
        chk("R2 to cascade step", init_active, 1);
        wrq(1, 8'h04);
        chk("R3 cascade leaves mask", line_mask, 0);
        chk("R3 cascade to mode", init_active, 1);
        wrq(1, 8'h12);
        chk("R3 nested", nested_mode, 1);
        chk("R3 auto eoi", auto_eoi, 1);
        chk("R3 back to idle", init_active, 0);
    endtask

    task automatic t_init_single_nomode();
        wrq(0, 8'h12);
        chk("R1 single flag", single_mode, 1);
        chk("R1 nested cleared", nested_mode, 0);
        chk("R1 auto eoi cleared", auto_eoi, 0);
        wrq(1, 8'h27);
        chk("R2 vector base single", vec_base, 8'h20);
        chk("R2 single no mode word idle", init_active, 0);
    endtask

    task automatic t_init_single_mode();
        wrq(0, 8'h13);
        wrq(1, 8'h08);
        chk("R2 single+mode word to mode step", init_active, 1);
        wrq(1, 8'h02);
        chk("R3 auto eoi only", auto_eoi, 1);
        chk("R3 nested off", nested_mode, 0);
        chk("R3 idle after mode", init_active, 0);
    endtask

    task automatic t_init_cascade_nomode();
        logic [7:0] d; logic av; logic [2:0] ai;
        wrq(0, 8'h10);
        wrq(1, 8'h30);
        wrq(1, 8'h55);
        chk("R3 cascade no mode idle", init_active, 0);
        chk("R4 mask untouched during init", line_mask, 0);
        wrq(1, 8'hA5);
        chk("R4 idle mask load", line_mask, 8'hA5);
        rd(1, d, av, ai);
        chk("R9 read mask", d, 8'hA5);
    endtask

    task automatic t_ocw3();
        logic [7:0] d; logic av; logic [2:0] ai;
        isr_in = 8'h3C; irr_in = 8'hC1;
        rd(0, d, av, ai);
        chk("R9 default read request reg", d, 8'hC1);
        wrq(0, 8'h0B);
        rd(0, d, av, ai);
        chk("R5 select in-service", d, 8'h3C);
        wrq(0, 8'h08);
        rd(0, d, av, ai);
        chk("R5 bit1 clear keeps select", d, 8'h3C);
        wrq(0, 8'h0A);
        rd(0, d, av, ai);
        chk("R5 select request", d, 8'hC1);
        wrq(0, 8'h68);
        chk("R5 special mask set", spec_mask, 1);
        wrq(0, 8'h28);
        chk("R5 bit6 clear keeps special mask", spec_mask, 1);
        wrq(0, 8'h48);
        chk("R5 special mask cleared", spec_mask, 0);
    endtask

    task automatic t_rotate();
        wrq(0, 8'h80);
        chk("R6 code4 rotate on", rotate_aeoi, 1);
        wrq(0, 8'h00);
        chk("R6 code0 rotate off", rotate_aeoi, 0);
    endtask

    task automatic t_eoi_nonspecific();
        logic ev, clr; logic [2:0] ei;
        top_isr_valid = 1; top_isr_idx = 3'd5;
        wr(0, 8'h20, ev, ei, clr);
        chk("R7 code1 pulse", ev, 1);
        chk("R7 code1 line", ei, 5);
        chk("R7 code1 offset kept", prio_offset, 0);
        wr(0, 8'hA0, ev, ei, clr);
        chk("R7 code5 pulse", ev, 1);
        chk("R7 code5 offset", prio_offset, 6);
        top_isr_valid = 0; top_isr_idx = 3'd2;
        wr(0, 8'h20, ev, ei, clr);
        chk("R7 code1 nothing in service", ev, 0);
        wr(0, 8'hA0, ev, ei, clr);
        chk("R7 code5 nothing in service pulse", ev, 0);
        chk("R7 code5 nothing in service offset", prio_offset, 6);
    endtask

    task automatic t_eoi_specific();
        logic ev, clr; logic [2:0] ei;
        wr(0, 8'h63, ev, ei, clr);
        chk("R8 code3 pulse", ev, 1);
        chk("R8 code3 line", ei, 3);
        chk("R8 code3 offset kept", prio_offset, 6);
        wr(0, 8'hE7, ev, ei, clr);
        chk("R8 code7 line", ei, 7);
        chk("R8 code7 offset wraps", prio_offset, 0);
        wr(0, 8'hC4, ev, ei, clr);
        chk("R8 code6 no pulse", ev, 0);
        chk("R8 code6 offset", prio_offset, 5);
        wr(0, 8'h40, ev, ei, clr);
        chk("R8 code2 no pulse", ev, 0);
        chk("R8 code2 offset kept", prio_offset, 5);
    endtask

    task automatic t_icw1_clears();
        wrq(1, 8'h77);
        wrq(0, 8'h0C);
        wrq(0, 8'h68);
        wrq(0, 8'h80);
        wrq(0, 8'h1A);
        chk("R1 mask cleared", line_mask, 0);
        chk("R1 offset cleared", prio_offset, 0);
        chk("R1 poll cleared", poll_mode, 0);
        chk("R1 special mask cleared", spec_mask, 0);
        chk("R1 rotate cleared", rotate_aeoi, 0);
        wrq(1, 8'h40);
    endtask

    task automatic t_poll();
        logic [7:0] d; logic av; logic [2:0] ai;
        irr_in = 8'h81;
        wrq(0, 8'h0C);
        chk("R5 poll armed", poll_mode, 1);
        top_req_valid = 1; top_req_idx = 3'd6;
        rd(0, d, av, ai);
        chk("R10 poll word", d, 8'h86);
        chk("R10 ack pulse", av, 1);
        chk("R10 ack line", ai, 6);
        chk("R10 poll cleared", poll_mode, 0);
        rd(0, d, av, ai);
        chk("R9 normal read after poll", d, 8'h81);
        wrq(0, 8'h0C);
        top_req_valid = 0;
        rd(0, d, av, ai);
        chk("R10 empty poll word", d, 0);
        chk("R10 empty poll no ack", av, 0);
        chk("R10 empty poll cleared", poll_mode, 0);
    endtask

    task automatic t_trig();
        @(negedge clk); trig_wr = 1; trig_wdata = 8'hFF;
        @(negedge clk); trig_wr = 0;
        chk("R11 trig masked all", trig_level, 8'hDE);
        @(negedge clk); trig_wr = 1; trig_wdata = 8'h21;
        @(negedge clk); trig_wr = 0;
        chk("R11 trig masked none", trig_level, 8'h00);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_init_cascade_mode();
        t_init_single_nomode();
        t_init_single_mode();
        t_init_cascade_nomode();
        t_ocw3();
        t_rotate();
        t_eoi_nonspecific();
        t_eoi_specific();
        t_icw1_clears();
        t_poll();
        t_trig();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule